// File: doc/BRIEF.md
# Parallel Printer Handshake Port

This block sits between a byte source, such as a serial receiver that delivers characters of 8 data bits with no parity and one stop bit at 1200 bit/s, and a parallel printer. Each character arrives over a valid/ready handshake. The block keeps the character until the printer says it is free. It then puts the byte on an 8-bit data bus and gives a low pulse on an active-low strobe line.

The printer reports that it is occupied by pulling an active-low busy line low. The block passes that line through a two-flop synchronizer, then waits until it reads high. The byte is placed on the bus one clock before the strobe falls and is held one clock after the strobe rises. The width of the strobe pulse, in clock cycles, comes from an input. A value of zero is treated as one. The input ready signal stays low from the moment a byte is accepted until its pulse has finished, so the source is held off and no character is lost.

Top module: `prn_handshake_port`

## Requirements
- R1: After reset, strobe_n is 1, in_ready is 1 and prn_data is 0.
- R2: A byte is accepted on a rising edge where in_valid and in_ready are both 1. in_ready is 0 from the next cycle until one cycle after strobe_n has returned to 1. It is 1 again in the cycle after that.
- R3: While busy_n is 0, strobe_n stays 1. When busy_n rises while a byte is waiting, strobe_n falls on the 4th rising edge after the rise: two edges pass through the synchronizer, one edge is the decision and one is the setup clock.
- R4: When busy_n has been 1 for at least two cycles, strobe_n falls on the 2nd rising edge after the accepting edge.
- R5: strobe_n stays 0 for max(1, strobe_width) cycles, where strobe_width is an unsigned count held constant during the transfer.
- R6: prn_data equals the accepted byte in the cycle before strobe_n falls, during every cycle that strobe_n is 0, and in the cycle after strobe_n rises.
- R7: in_valid and in_data have no effect while in_ready is 0. prn_data keeps the byte already taken, and only that byte is strobed.
- R8: Each accepted byte produces exactly one strobe pulse. Pulses occur in the order in which the bytes were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a byte |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Offered byte |
| strobe_width | input | WW (4) | Strobe low time in cycles; 0 means 1 |
| busy_n | input | 1 | Printer busy, active low, asynchronous |
| prn_data | output | 8 | Printer data bus |
| strobe_n | output | 1 | Printer strobe, active low |

## Verification
The strobe width is swept over every value of the 4-bit width input, including zero, with a different byte each time. This separates a correct pulse length from an off-by-one error or a missing clamp at zero. With the printer free, the distance from acceptance to the falling strobe tells a missing or doubled setup stage apart from the intended one. With the printer held busy, a second byte is offered during the wait. That stimulus shows whether the wait is honoured, whether the synchronizer depth is right, and whether a byte offered while not ready is wrongly latched. A record of every falling edge checks that each byte is strobed exactly once and in order.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_WAIT,
    PS_SETUP,
    PS_PULSE,
    PS_HOLD
  } prn_state_t;

  // Strobe low time in cycles; a programmed zero is clamped to one.
  function automatic int unsigned strobe_cycles(input int unsigned w);
    return (w == 0) ? 1 : w;
  endfunction
endpackage

// File: rtl/prn_busy_sync.sv
module prn_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  // Resets to 0: printer treated as busy until the line is seen high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/prn_strobe_timer.sv
module prn_strobe_timer
  import prn_port_pkg::*;
#(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] width,
  output logic          active,
  output logic          done
);
  logic [WW-1:0] cnt;

  assign done = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= WW'(strobe_cycles(int'(width)) - 1);
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/prn_seq.sv
module prn_seq
  import prn_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       printer_free,
  input  logic       pulse_done,
  output logic       in_ready,
  output logic       pulse_start,
  output logic       fire_ok,
  output logic [7:0] out_data
);
  prn_state_t state, state_nx;
  logic accept;

  assign in_ready    = (state == PS_IDLE);
  assign accept      = in_valid && in_ready;
  assign fire_ok     = (state == PS_WAIT) && printer_free;
  assign pulse_start = (state == PS_SETUP);

  always_comb begin
    state_nx = state;
    case (state)
      PS_IDLE:  if (accept) state_nx = PS_WAIT;
      PS_WAIT:  if (printer_free) state_nx = PS_SETUP;
      PS_SETUP: state_nx = PS_PULSE;
      PS_PULSE: if (pulse_done) state_nx = PS_HOLD;
      PS_HOLD:  state_nx = PS_IDLE;
      default:  state_nx = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_IDLE;
      out_data <= '0;
    end else begin
      state <= state_nx;
      if (accept) out_data <= in_data;
    end
  end

  // The data register changes only on an accepted byte.
  assert_data_only_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(out_data));
endmodule

// File: rtl/prn_handshake_port.sv
module prn_handshake_port
  import prn_port_pkg::*;
#(
  parameter int WW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic [WW-1:0] strobe_width,
  input  logic          busy_n,
  output logic [7:0]    prn_data,
  output logic          strobe_n
);
  logic printer_free;
  logic pulse_start, pulse_done, pulse_active;
  logic fire_ok;

  prn_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(busy_n), .dout(printer_free)
  );

  prn_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data),
    .printer_free(printer_free), .pulse_done(pulse_done),
    .in_ready(in_ready), .pulse_start(pulse_start),
    .fire_ok(fire_ok), .out_data(prn_data)
  );

  prn_strobe_timer #(.WW(WW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(pulse_start), .width(strobe_width),
    .active(pulse_active), .done(pulse_done)
  );

  assign strobe_n = ~pulse_active;

  assert_ready_low_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> !in_ready);

  assert_accept_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> strobe_n);

  assert_fire_after_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> $past(fire_ok, 2));

  assert_data_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> $stable(prn_data));

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |=> $stable(prn_data));
endmodule

// File: tb/prn_handshake_port_tb_top.sv
module prn_handshake_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [3:0] strobe_width = 4'd1;
  logic       busy_n = 1'b1;
  logic [7:0] prn_data;
  logic       strobe_n;

  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 0;

  logic [7:0] sent_log [0:63];
  logic [7:0] seen_log [0:63];
  int n_sent = 0;
  int n_seen = 0;
  logic prev_sn = 1'b1;

  always #10 clk = ~clk;

  prn_handshake_port #(.WW(4), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .strobe_width(strobe_width), .busy_n(busy_n),
    .prn_data(prn_data), .strobe_n(strobe_n)
  );

  // Record the data on every falling strobe (R8).
  always @(negedge clk) begin
    if (rst_n && prev_sn && !strobe_n && n_seen < 64) begin
      seen_log[n_seen] = prn_data;
      n_seen++;
    end
    prev_sn = strobe_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  function automatic int exp_low(input int w);
    if (w < 1) return 1;
    return w;
  endfunction

  // Offer one byte; exp_high is the number of strobe-high samples after acceptance.
  task automatic send_byte(input logic [7:0] b, input int w, input int exp_high);
    int hi;
    int lo;
    logic [7:0] before_fall;
    strobe_width = 4'(w);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready before offer", int'(in_ready), 1);
    in_data = b;
    in_valid = 1'b1;
    sent_log[n_sent] = b;
    n_sent++;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 ready drops after accept", int'(in_ready), 0);
    hi = 0;
    before_fall = prn_data;
    while (strobe_n && hi < 60) begin
      hi++;
      before_fall = prn_data;
      @(negedge clk);
    end
    check(hi == exp_high, "R4 strobe fall delay", hi, exp_high);
    check(before_fall == b, "R6 data before fall", int'(before_fall), int'(b));
    lo = 0;
    while (!strobe_n && lo < 60) begin
      lo++;
      if (prn_data != b) check(0, "R6 data during strobe", int'(prn_data), int'(b));
      @(negedge clk);
    end
    check(lo == exp_low(w), "R5 strobe low width", lo, exp_low(w));
    check(prn_data == b, "R6 data after rise", int'(prn_data), int'(b));
    check(in_ready == 1'b0, "R2 ready low one cycle after rise", int'(in_ready), 0);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready returns", int'(in_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int hi;
    int lo;
    bit stayed;
    repeat (3) @(negedge clk);
    check(strobe_n == 1'b1, "R1 strobe_n at reset", int'(strobe_n), 1);
    check(in_ready == 1'b1, "R1 in_ready at reset", int'(in_ready), 1);
    check(prn_data == 8'h00, "R1 prn_data at reset", int'(prn_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep every strobe width, including zero (R4, R5, R6).
    for (int w = 0; w < 16; w++) send_byte(8'((w * 37 + 11) & 255), w, 2);

    // Busy wait with a second byte offered while not ready (R3, R7).
    busy_n = 1'b0;
    strobe_width = 4'd3;
    @(negedge clk);
    in_data = 8'hA5;
    in_valid = 1'b1;
    sent_log[n_sent] = 8'hA5;
    n_sent++;
    @(negedge clk);
    in_data = 8'h3C;
    stayed = 1;
    for (int i = 0; i < 25; i++) begin
      if (!strobe_n || in_ready || prn_data != 8'hA5) stayed = 0;
      @(negedge clk);
    end
    check(stayed, "R3 no strobe while busy", int'(stayed), 1);
    check(prn_data == 8'hA5, "R7 byte offered while not ready ignored", int'(prn_data), 8'hA5);
    in_valid = 1'b0;
    busy_n = 1'b1;
    hi = 0;
    @(negedge clk);
    while (strobe_n && hi < 60) begin
      hi++;
      @(negedge clk);
    end
    check(hi == 3, "R3 strobe falls on 4th edge after busy release", hi, 3);
    check(prn_data == 8'hA5, "R7 strobed byte is the first one", int'(prn_data), 8'hA5);
    lo = 0;
    while (!strobe_n && lo < 60) begin
      lo++;
      @(negedge clk);
    end
    check(lo == 3, "R5 width after busy wait", lo, 3);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready after busy transfer", int'(in_ready), 1);

    // Back-to-back transfers, printer free again.
    send_byte(8'hFF, 2, 2);
    send_byte(8'h00, 1, 2);
    repeat (4) @(negedge clk);

    check(n_seen == n_sent, "R8 one strobe per byte", n_seen, n_sent);
    for (int i = 0; i < n_sent; i++)
      if (seen_log[i] != sent_log[i])
        check(0, "R8 strobe order", int'(seen_log[i]), int'(sent_log[i]));
    check(1, "R8 order scan complete", 1, 1);
    finish_run();
  end
endmodule